// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Hourly Drift Trim

This block keeps wall-clock time as packed BCD bytes: seconds, minutes, hours (24-hour), day of month, month and a two-digit year read as 2000 to 2099. An enable `tick_i`, nominally at 32768 Hz, advances a sub-second prescaler. Each wrap of the prescaler steps the calendar by one second. Month lengths follow the calendar, and February has 29 days whenever the BCD year is a multiple of four.

Software reaches the block through a byte-wide register port. Reads never see the running counters. A snapshot command copies the live time into a shadow bank, and the time addresses return that shadow. To set the time, software clears the run bit, writes the six time bytes and sets the run bit again.

A signed 16-bit trim value corrects crystal drift. While automatic trim is enabled, the trim is loaded into the prescaler once per hour, on the seconds step from 00 to 01 at minute 00. A positive value shortens the following second. A negative value repeats second 00 for a shortened interval. The trim code 0x7FFF is illegal and is never stored.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the live time and the shadow time are both 00:00:00, day 01, month 01, year 00. The control byte reads 0x00 (clock stopped) and the trim reads 0x0000.
- R2: The address map is as follows. Addresses 0..5 are seconds, minutes, hours, day, month, year. Address 6 is control, with bit0 = run, bit1 = snapshot and bit2 = auto-trim. Address 7 is the trim low byte and address 8 the trim high byte; any other address reads 0x00. A write to addresses 0..5 loads the live counter. A write to address 0 also clears the prescaler.
- R3: Reads of addresses 0..5 return the shadow bank. Writing control with bit1 set copies the live time into the shadow on the following clock edge. Bit1 reads 1 for exactly one cycle and then clears itself, and the shadow holds its value until the next snapshot.
- R4: Time advances only while run is 1, and only on cycles where `tick_i` is 1. One second passes every TICKS counted ticks.
- R5: Seconds and minutes roll over from 59 to 00 and carry into the next field. Hours roll over from 23 to 00 and carry into the day.
- R6: The day rolls over to 01 after the last day of the month, which is 30 for months 04, 06, 09 and 11. February ends on day 29 when the BCD year is divisible by 4 and on day 28 otherwise, and every other month ends on day 31. Month 12 rolls over to 01 and carries into the year, and year 99 rolls over to 00.
- R7: A write to address 7 only stages the low byte. A write to address 8 commits {high, staged low} as the trim, unless that value is 0x7FFF, in which case the previous trim is kept. Addresses 7 and 8 read back the committed trim.
- R8: With auto-trim on and a non-negative trim T, the seconds step from 00 to 01 at minute 00 loads T into the prescaler. The next second therefore lasts TICKS-T ticks.
- R9: With auto-trim on and a negative trim T, the 00-to-01 step at minute 00 is replaced by a borrow. Seconds stay at 00 and the prescaler is loaded with TICKS+T. The trim is applied at most once per hour, and a write to the seconds address re-arms it.
- R10: No trim is applied while auto-trim is off, or on any 00-to-01 seconds step at a minute other than 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Reference tick enable (TICKS per second) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address for both read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |

## Verification
The range assertions on the live counters assume that software writes only legal packed BCD values, with hours up to 23 and day 01 to 31. The stimulus builds every written time from legal binary fields and converts them to BCD. Day values are drawn only up to the length of the chosen month. The bench runs with a small TICKS so that many rollovers fit in the run. Every trim magnitude it uses stays below TICKS, which keeps the prescaler load away from its clamp.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] day;
    logic [7:0] hr;
    logic [7:0] mn;
    logic [7:0] sec;
  } rtc_time_t;

  localparam int ADDR_SEC    = 0;
  localparam int ADDR_MIN    = 1;
  localparam int ADDR_HR     = 2;
  localparam int ADDR_DAY    = 3;
  localparam int ADDR_MON    = 4;
  localparam int ADDR_YR     = 5;
  localparam int ADDR_CTRL   = 6;
  localparam int ADDR_TRM_LO = 7;
  localparam int ADDR_TRM_HI = 8;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_SNAP = 1;
  localparam int CTRL_AUTO = 2;

  localparam logic [15:0] TRIM_ILLEGAL = 16'h7FFF;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_year(input logic [7:0] yr);
    logic [7:0] bin;
    bin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS = 32768
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        run_i,
  input  logic        auto_i,
  input  logic [15:0] trim_i,
  input  logic [7:0]  sec_i,
  input  logic [7:0]  min_i,
  input  logic        rearm_i,
  output logic        adv_o
);
  localparam int PW = $clog2(TICKS);
  localparam int signed TK = TICKS;

  logic [PW-1:0] cnt_q;
  logic          armed_q;
  logic          count_en, step, hour_hit;
  logic signed [31:0] tv, nv;

  assign count_en = tick_i & run_i;
  assign step     = count_en & (cnt_q == PW'(TICKS - 1));
  assign hour_hit = step & auto_i & armed_q & (sec_i == 8'h00) & (min_i == 8'h00);
  assign adv_o    = step & ~(hour_hit & trim_i[15]);

  always_comb begin
    tv = {{16{trim_i[15]}}, trim_i};
    if (!trim_i[15]) nv = (tv > TK - 1) ? TK - 1 : tv;
    else             nv = (tv + TK < 0) ? 0 : tv + TK;  // borrow: wrap into this second
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (rearm_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (step) begin
      cnt_q <= hour_hit ? nv[PW-1:0] : '0;
      if (hour_hit)              armed_q <= 1'b0;
      else if (sec_i != 8'h00)   armed_q <= 1'b1;
    end else if (count_en) begin
      cnt_q <= cnt_q + PW'(1);
    end
  end

  p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= PW'(TICKS - 1));
  p_hold_stopped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!count_en && !rearm_i) |=> $stable(cnt_q));
  p_trim_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hour_hit && !rearm_i) |=> !armed_q);
  p_no_trim_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !auto_i && !rearm_i) |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output rtc_time_t  time_o
);
  rtc_time_t cur_q, nxt;
  logic [7:0] last_day;

  assign last_day = month_last(cur_q.mon, cur_q.yr);
  assign time_o   = cur_q;

  always_comb begin
    nxt = cur_q;
    if (wr_en_i) begin
      case (wr_sel_i)
        3'd0:    nxt.sec = wr_data_i;
        3'd1:    nxt.mn  = wr_data_i;
        3'd2:    nxt.hr  = wr_data_i;
        3'd3:    nxt.day = wr_data_i;
        3'd4:    nxt.mon = wr_data_i;
        default: nxt.yr  = wr_data_i;
      endcase
    end else if (adv_i) begin
      if (cur_q.sec != 8'h59) nxt.sec = bcd_inc(cur_q.sec);
      else begin
        nxt.sec = 8'h00;
        if (cur_q.mn != 8'h59) nxt.mn = bcd_inc(cur_q.mn);
        else begin
          nxt.mn = 8'h00;
          if (cur_q.hr != 8'h23) nxt.hr = bcd_inc(cur_q.hr);
          else begin
            nxt.hr = 8'h00;
            if (cur_q.day != last_day) nxt.day = bcd_inc(cur_q.day);
            else begin
              nxt.day = 8'h01;
              if (cur_q.mon != 8'h12) nxt.mon = bcd_inc(cur_q.mon);
              else begin
                nxt.mon = 8'h01;
                nxt.yr  = (cur_q.yr == 8'h99) ? 8'h00 : bcd_inc(cur_q.yr);
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '{yr: 8'h00, mon: 8'h01, day: 8'h01, hr: 8'h00, mn: 8'h00, sec: 8'h00};
    else         cur_q <= nxt;
  end

  p_sec_bcd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q.sec[3:0] <= 4'd9) && (cur_q.sec <= 8'h59));
  p_hr_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q.hr <= 8'h23);
  p_sec_moves_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_en_i) |=> (cur_q.sec != $past(cur_q.sec)));
  p_day_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q.day != 8'h00) && (cur_q.day <= 8'h31));
  p_month_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_en_i && cur_q.sec == 8'h59 && cur_q.mn == 8'h59 &&
     cur_q.hr == 8'h23 && cur_q.day == last_day) |=> (cur_q.day == 8'h01));

endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  rtc_time_t     live_i,
  output logic          run_o,
  output logic          auto_o,
  output logic [15:0]   trim_o,
  output logic [7:0]    rdata_o
);
  rtc_time_t   shadow_q;
  logic        run_q, auto_q, snap_q;
  logic [7:0]  stage_q;
  logic [15:0] trim_q;
  logic        wr_ctrl, wr_lo, wr_hi;
  logic [15:0] trim_cand;

  assign wr_ctrl   = wr_en_i && (addr_i == AW'(ADDR_CTRL));
  assign wr_lo     = wr_en_i && (addr_i == AW'(ADDR_TRM_LO));
  assign wr_hi     = wr_en_i && (addr_i == AW'(ADDR_TRM_HI));
  assign trim_cand = {wdata_i, stage_q};

  assign run_o  = run_q;
  assign auto_o = auto_q;
  assign trim_o = trim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      auto_q <= 1'b0;
      snap_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_q  <= wdata_i[CTRL_RUN];
      auto_q <= wdata_i[CTRL_AUTO];
      snap_q <= wdata_i[CTRL_SNAP];
    end else begin
      snap_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= '{yr: 8'h00, mon: 8'h01, day: 8'h01, hr: 8'h00, mn: 8'h00, sec: 8'h00};
    else if (snap_q) shadow_q <= live_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      trim_q  <= '0;
    end else begin
      if (wr_lo) stage_q <= wdata_i;
      if (wr_hi && trim_cand != TRIM_ILLEGAL) trim_q <= trim_cand;
    end
  end

  always_comb begin
    case (addr_i)
      AW'(ADDR_SEC):    rdata_o = shadow_q.sec;
      AW'(ADDR_MIN):    rdata_o = shadow_q.mn;
      AW'(ADDR_HR):     rdata_o = shadow_q.hr;
      AW'(ADDR_DAY):    rdata_o = shadow_q.day;
      AW'(ADDR_MON):    rdata_o = shadow_q.mon;
      AW'(ADDR_YR):     rdata_o = shadow_q.yr;
      AW'(ADDR_CTRL):   rdata_o = {5'd0, auto_q, snap_q, run_q};
      AW'(ADDR_TRM_LO): rdata_o = trim_q[7:0];
      AW'(ADDR_TRM_HI): rdata_o = trim_q[15:8];
      default:          rdata_o = 8'h00;
    endcase
  end

  p_snap_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_q && !(wr_ctrl && wdata_i[CTRL_SNAP])) |=> !snap_q);
  p_shadow_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_q |=> $stable(shadow_q));
  p_trim_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trim_q != TRIM_ILLEGAL);
  p_trim_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hi |=> $stable(trim_q));

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int TICKS = 32768,
  parameter int AW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  rtc_time_t   live;
  logic        run, auto_en, adv, time_wr, sec_wr;
  logic [15:0] trim;

  assign time_wr = wr_en_i && (addr_i <= AW'(ADDR_YR));
  assign sec_wr  = wr_en_i && (addr_i == AW'(ADDR_SEC));

  rtc_regs #(.AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .live_i  (live),
    .run_o   (run),
    .auto_o  (auto_en),
    .trim_o  (trim),
    .rdata_o (rdata_o)
  );

  rtc_prescaler #(.TICKS(TICKS)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .run_i   (run),
    .auto_i  (auto_en),
    .trim_i  (trim),
    .sec_i   (live.sec),
    .min_i   (live.mn),
    .rearm_i (sec_wr),
    .adv_o   (adv)
  );

  rtc_calendar u_cal (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .wr_en_i   (time_wr),
    .wr_sel_i  (addr_i[2:0]),
    .wr_data_i (wdata_i),
    .time_o    (live)
  );

  p_stopped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !time_wr) |=> $stable(live));

endmodule

// File: tb/tb_rtc_bcd_core.sv
module tb_rtc_bcd_core;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       wr_en_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] ctrl_sh = 8'h00;

  rtc_bcd_core #(.TICKS(TICKS), .AW(4)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int bcd2b(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction
  function automatic logic [7:0] b2bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction
  function automatic logic [47:0] pack_t(input int y, mo, d, h, mi, s);
    return {b2bcd(y), b2bcd(mo), b2bcd(d), b2bcd(h), b2bcd(mi), b2bcd(s)};
  endfunction
  function automatic logic [47:0] next_sec(input logic [47:0] t);
    int s, mi, h, d, mo, y;
    s = bcd2b(t[7:0]); mi = bcd2b(t[15:8]); h = bcd2b(t[23:16]);
    d = bcd2b(t[31:24]); mo = bcd2b(t[39:32]); y = bcd2b(t[47:40]);
    s++;
    if (s == 60) begin s = 0; mi++; end
    if (mi == 60) begin mi = 0; h++; end
    if (h == 24) begin h = 0; d++; end
    if (d > dim(mo, y)) begin d = 1; mo++; end
    if (mo == 13) begin mo = 1; y++; end
    if (y == 100) y = 0;
    return pack_t(y, mo, d, h, mi, s);
  endfunction

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic read_time(output logic [47:0] t);
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b;
      rd(4'(i), b);
      t[i*8 +: 8] = b;
    end
  endtask

  task automatic snap(output logic [47:0] t);
    wr(4'd6, ctrl_sh | 8'h02);
    @(negedge clk);
    read_time(t);
  endtask

  task automatic set_time(input logic [47:0] t, input logic [7:0] ctl);
    wr(4'd6, ctl & 8'hFE);
    for (int i = 0; i < 6; i++) wr(4'(i), t[i*8 +: 8]);
    ctrl_sh = ctl | 8'h01;
    wr(4'd6, ctrl_sh);
  endtask

  task automatic set_trim(input logic [15:0] v);
    wr(4'd7, v[7:0]);
    wr(4'd8, v[15:8]);
  endtask

  task automatic run_snap(input int m, output logic [47:0] t);
    repeat (m) @(posedge clk);
    snap(t);
  endtask

  task automatic sec_case(input string req, input logic [47:0] t0);
    logic [47:0] got;
    set_time(t0, 8'h00);
    run_snap(20, got);
    chk(req, got, next_sec(t0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] t, t2;
    logic [7:0]  b, lo, hi;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_time(t);
    chk("R1 time", t, pack_t(0, 1, 1, 0, 0, 0));
    rd(4'd6, b); chk("R1 ctrl", {40'd0, b}, 48'h0);
    rd(4'd7, lo); rd(4'd8, hi); chk("R1 trim", {32'd0, hi, lo}, 48'h0);
    rd(4'd9, b); chk("R2 unmapped", {40'd0, b}, 48'h0);

    // R4 stopped clock does not move; R2 writes land in the time registers
    t2 = pack_t(37, 6, 14, 9, 41, 12);
    set_time(t2, 8'h00);
    ctrl_sh = 8'h00; wr(4'd6, 8'h00);
    repeat (60) @(posedge clk);
    snap(t);
    chk("R4 stopped/R2 load", t, t2);

    // R4 tick low stops counting
    ctrl_sh = 8'h01; wr(4'd6, 8'h01);
    tick_i = 1'b0;
    repeat (60) @(posedge clk);
    snap(t);
    chk("R4 tick gated", t, t2);
    tick_i = 1'b1;

    // R3 snapshot bit self-clears; shadow holds between snapshots
    wr(4'd6, ctrl_sh | 8'h02);
    rd(4'd6, b); chk("R3 snap bit set", {40'd0, b}, 48'h03);
    @(negedge clk);
    rd(4'd6, b); chk("R3 snap bit cleared", {40'd0, b}, 48'h01);
    read_time(t);
    repeat (3 * TICKS) @(posedge clk);
    @(negedge clk);
    read_time(t2);
    chk("R3 shadow holds", t2, t);

    // R4 one second per TICKS ticks
    t = pack_t(10, 3, 3, 3, 3, 3);
    set_time(t, 8'h00);
    run_snap(TICKS + 4 + 2 * TICKS, t2);
    chk("R4 three seconds", t2, next_sec(next_sec(next_sec(t))));

    // R5 / R6 directed rollovers
    sec_case("R5 minute carry", pack_t(5, 5, 5, 5, 5, 59));
    sec_case("R5 hour carry", pack_t(5, 5, 5, 5, 59, 59));
    sec_case("R5 day carry", pack_t(5, 5, 5, 23, 59, 59));
    sec_case("R6 year wrap", pack_t(99, 12, 31, 23, 59, 59));
    sec_case("R6 leap feb28", pack_t(24, 2, 28, 23, 59, 59));
    sec_case("R6 leap feb29", pack_t(24, 2, 29, 23, 59, 59));
    sec_case("R6 common feb28", pack_t(23, 2, 28, 23, 59, 59));
    sec_case("R6 year00 feb28", pack_t(0, 2, 28, 23, 59, 59));
    sec_case("R6 april30", pack_t(30, 4, 30, 23, 59, 59));
    sec_case("R6 nov30", pack_t(30, 11, 30, 23, 59, 59));
    sec_case("R6 jan31", pack_t(30, 1, 31, 23, 59, 59));

    // R5 R6 random times, biased toward field maxima
    for (int n = 0; n < 40; n++) begin
      int y, mo, d, h, mi, s;
      y  = ($urandom % 4 == 0) ? 99 : int'($urandom % 100);
      mo = ($urandom % 3 == 0) ? 12 : int'($urandom % 12) + 1;
      d  = ($urandom % 2 == 0) ? dim(mo, y) : int'($urandom % dim(mo, y)) + 1;
      h  = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
      mi = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
      s  = ($urandom % 3 != 0) ? 59 : int'($urandom % 60);
      sec_case("R6 random", pack_t(y, mo, d, h, mi, s));
    end

    // R7 trim register staging and illegal code
    set_trim(16'h0005);
    rd(4'd7, lo); rd(4'd8, hi); chk("R7 trim load", {32'd0, hi, lo}, 48'h0005);
    set_trim(16'h7FFF);
    rd(4'd7, lo); rd(4'd8, hi); chk("R7 illegal ignored", {32'd0, hi, lo}, 48'h0005);
    wr(4'd7, 8'hAA);
    rd(4'd7, lo); chk("R7 low staged only", {40'd0, lo}, 48'h05);
    set_trim(16'h8000);
    rd(4'd7, lo); rd(4'd8, hi); chk("R7 min trim", {32'd0, hi, lo}, 48'h8000);
    set_trim(16'h7FFE);
    rd(4'd7, lo); rd(4'd8, hi); chk("R7 max trim", {32'd0, hi, lo}, 48'h7FFE);

    // R8 positive trim shortens the second after 00->01 at minute 00
    set_trim(16'd5);
    set_time(pack_t(20, 5, 5, 5, 0, 0), 8'h04);
    run_snap(27, t);
    chk("R8 positive trim", t, pack_t(20, 5, 5, 5, 0, 2));

    // R10 no trim with auto off
    set_time(pack_t(20, 5, 5, 5, 0, 0), 8'h00);
    run_snap(27, t);
    chk("R10 auto off", t, pack_t(20, 5, 5, 5, 0, 1));

    // R10 no trim at minute other than 00
    set_time(pack_t(20, 5, 5, 5, 1, 0), 8'h04);
    run_snap(27, t);
    chk("R10 minute 01", t, pack_t(20, 5, 5, 5, 1, 1));

    // R9 negative trim borrows, then once per hour
    set_trim(16'hFFFB);
    set_time(pack_t(20, 5, 5, 5, 0, 0), 8'h04);
    run_snap(17, t);
    chk("R9 borrow holds 00", t, pack_t(20, 5, 5, 5, 0, 0));
    set_time(pack_t(20, 5, 5, 5, 0, 0), 8'h04);
    run_snap(21, t);
    chk("R9 short second", t, pack_t(20, 5, 5, 5, 0, 1));
    set_time(pack_t(20, 5, 5, 5, 0, 0), 8'h04);
    run_snap(37, t);
    chk("R9 applied once", t, pack_t(20, 5, 5, 5, 0, 2));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule